// File: doc/BRIEF.md
# Auto-Incrementing Buffer Access Port

This block is a register-mapped window into two small on-chip buffers used by a memory test engine to hold pattern and compare data. Each buffer entry holds a 64-bit data word and 8 check bits. Host software first writes a control register. That register picks the buffer, sets the entry pointer, turns stepping on or off, and chooses whether check bits come from the host or from an internal generator. Data words and check bits then move through two further registers.

A data register write only stages the word. The entry is stored when the check-bit register is written next. When stepping is on, every access to the check-bit register, read or write, moves the pointer to the next entry. The pointer wraps at the end of the buffer, so reads can run past the buffer size and go round it in a circle. To load a 128-byte line in two 64-byte halves, the host writes the first half from entry 0, then rewrites the control register with the pointer at entry 8 and writes the second half.

Top module: `buf_access_port`

## Requirements
- R1: After reset the pointer, buffer select, stepping enable and generate enable are all zero, and a control register read returns 0.
- R2: A write to the data register (regAddr=1) only stages the word. The buffer entry at the pointer keeps its old contents until a write to the check register (regAddr=2) stores the staged word there.
- R3: With generate off, a check register write stores regWdata[7:0] as the entry's check bits.
- R4: With generate on, the value written to the check register is ignored. Check bit i is stored as the XOR of data bits [8i+7:8i] of the staged word.
- R5: With stepping on, the pointer advances by one after every check register access, both reads and writes. With stepping off, and for any data register access, the pointer holds.
- R6: The pointer wraps from the last entry (31 by default) to 0. Repeated reads therefore go round the buffer in a circle.
- R7: A data register read returns the data word of the selected buffer at the pointer in the same cycle and changes no state.
- R8: A check register read returns the stored check bits in regRdata[7:0], with zeros above them.
- R9: A control register write (regAddr=0) loads the pointer from bits [4:0], the buffer select from bit 8, stepping from bit 9 and generate from bit 10. A control register read returns those fields in the same positions, with the live pointer.
- R10: The two buffers are independent. Writes with buffer select 1 never alter buffer 0, and the reverse.
- R11: Register address 3 reads as 0, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Register access in this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 2 | 0 control, 1 data, 2 check bits, 3 unused |
| regWdata | input | 64 | Write data |
| regRdata | output | 64 | Read data for regAddr, combinational |

## Verification
The bench builds the block with its default parameters: a 5-bit pointer, 32 entries per buffer and 64-bit words. With that size every entry of both buffers can be filled and read back under host-supplied and generated check bits, and the pointer wrap occurs on each full pass. The data words are a multiplicative hash of buffer and index, so every byte pattern differs and the expected parity is computed arithmetically in the bench. Directed sequences then cover staging without commit, stepping held off, reads that run over the wrap, and the unused address.

// File: rtl/bufport_pkg.sv
package bufport_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_DATA = 2'd1,
    REG_ECC  = 2'd2,
    REG_NONE = 2'd3
  } regSel_e;

  localparam int NUM_BUF  = 2;
  localparam int BUF_BIT  = 8;
  localparam int STEP_BIT = 9;
  localparam int GEN_BIT  = 10;

  typedef struct packed {
    logic stage;
    logic commit;
    logic eccGen;
    logic bufSel;
  } strobe_t;
endpackage

// File: rtl/bufport_ctrl.sv
module bufport_ctrl
  import bufport_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output strobe_t           strb,
  output logic [ADDR_W-1:0] ptr,
  output logic [DATA_W-1:0] ctrlWord
);
  logic              bufSelQ, stepQ, genQ;
  logic [ADDR_W-1:0] ptrQ;
  logic              ctrlWr, eccAcc;

  assign ctrlWr = regValid && regWrite && (regAddr == REG_CTRL);
  assign eccAcc = regValid && (regAddr == REG_ECC);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufSelQ <= 1'b0;
      stepQ   <= 1'b0;
      genQ    <= 1'b0;
      ptrQ    <= '0;
    end else if (ctrlWr) begin
      bufSelQ <= regWdata[BUF_BIT];
      stepQ   <= regWdata[STEP_BIT];
      genQ    <= regWdata[GEN_BIT];
      ptrQ    <= regWdata[ADDR_W-1:0];
    end else if (eccAcc && stepQ) begin
      ptrQ <= ptrQ + ADDR_W'(1);
    end
  end

  always_comb begin
    strb.stage  = regValid && regWrite && (regAddr == REG_DATA);
    strb.commit = eccAcc && regWrite;
    strb.eccGen = genQ;
    strb.bufSel = bufSelQ;
    ptr         = ptrQ;
    ctrlWord    = '0;
    ctrlWord[ADDR_W-1:0] = ptrQ;
    ctrlWord[BUF_BIT]    = bufSelQ;
    ctrlWord[STEP_BIT]   = stepQ;
    ctrlWord[GEN_BIT]    = genQ;
  end

  // R5 / R6: stepping moves the pointer by one, modulo the buffer size
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (eccAcc && stepQ) |=> (ptrQ == $past(ptrQ) + ADDR_W'(1)));

  // R5: data register accesses leave the pointer alone
  assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regAddr == REG_DATA) |=> $stable(ptrQ));

  // R9: control write repositions the pointer
  assert_ptr_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (ptrQ == $past(regWdata[ADDR_W-1:0])));
endmodule

// File: rtl/bufport_dp.sv
module bufport_dp
  import bufport_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] ctrlWord,
  output logic [DATA_W-1:0] regRdata
);
  localparam int DEPTH = 2 ** ADDR_W;
  localparam int ECC_W = DATA_W / 8;

  logic [DATA_W-1:0] stagedQ;
  logic [ECC_W-1:0]  genEcc, storeEcc;
  logic [DATA_W-1:0] memData [NUM_BUF][DEPTH];
  logic [ECC_W-1:0]  memEcc  [NUM_BUF][DEPTH];

  for (genvar i = 0; i < ECC_W; i++) begin : g_par
    assign genEcc[i] = ^stagedQ[i*8 +: 8];
  end

  assign storeEcc = strb.eccGen ? genEcc : regWdata[ECC_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) stagedQ <= '0;
    else if (strb.stage) stagedQ <= regWdata;
  end

  always_ff @(posedge clk) begin
    if (strb.commit) begin
      memData[strb.bufSel][ptr] <= stagedQ;
      memEcc[strb.bufSel][ptr]  <= storeEcc;
    end
  end

  always_comb begin
    case (regSel_e'(regAddr))
      REG_CTRL: regRdata = ctrlWord;
      REG_DATA: regRdata = memData[strb.bufSel][ptr];
      REG_ECC:  regRdata = {{(DATA_W-ECC_W){1'b0}}, memEcc[strb.bufSel][ptr]};
      default:  regRdata = '0;
    endcase
  end

  // R2: a commit stores the word staged before it
  assert_commit_data_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (memData[$past(strb.bufSel)][$past(ptr)] == $past(stagedQ)));

  // R2: staging alone never commits
  assert_stage_only_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stage && !strb.commit) |=> $stable(memData[$past(strb.bufSel)][$past(ptr)]));
endmodule

// File: rtl/buf_access_port.sv
module buf_access_port
  import bufport_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata
);
  strobe_t           strb;
  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] ctrlWord;

  bufport_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .strb(strb), .ptr(ptr),
    .ctrlWord(ctrlWord)
  );

  bufport_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ptr(ptr), .regAddr(regAddr),
    .regWdata(regWdata), .ctrlWord(ctrlWord), .regRdata(regRdata)
  );
endmodule

// File: tb/buf_access_port_tb.sv
module buf_access_port_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regValid = 1'b0;
  logic        regWrite = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [63:0] regWdata = '0;
  logic [63:0] regRdata;
  int errors = 0;
  int checks = 0;
  logic [63:0] rd;

  always #5 clk = ~clk;

  buf_access_port u_dut (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata)
  );

  function automatic logic [63:0] pat(input int b, input int i);
    logic [63:0] k;
    k = 64'(b * 32 + i + 1);
    return k * 64'h9E3779B97F4A7C15;
  endfunction

  function automatic logic [63:0] par(input logic [63:0] w);
    logic [63:0] p;
    p = '0;
    for (int j = 0; j < 8; j++) p[j] = ^w[j*8 +: 8];
    return p;
  endfunction

  function automatic logic [63:0] ctl(input int a, input bit b, input bit s, input bit g);
    logic [63:0] c;
    c = 64'(a & 31);
    c[8] = b; c[9] = s; c[10] = g;
    return c;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [63:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regValid = 1'b0;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    rdReg(2'd0, rd); chk("R1 ctrl reset", rd, 64'd0);

    // Fill buffer 0 with host check bits, stepping on (R3, R6)
    wr(2'd0, ctl(0, 0, 1, 0));
    for (int i = 0; i < 32; i++) begin
      wr(2'd1, pat(0, i));
      wr(2'd2, 64'(i ^ 8'hA5) | 64'hFF00);
    end
    rdReg(2'd0, rd); chk("R6 wrap after 32 writes", rd, ctl(0, 0, 1, 0));
    for (int i = 0; i < 32; i++) begin
      rdReg(2'd1, rd); chk("R7 data read", rd, pat(0, i));
      rdReg(2'd2, rd); chk("R3 R8 host check bits", rd, 64'(i ^ 8'hA5));
    end

    // Fill buffer 1 with generated check bits; value written ignored (R4, R10)
    wr(2'd0, ctl(0, 1, 1, 1));
    for (int i = 0; i < 32; i++) begin
      wr(2'd1, pat(1, i));
      wr(2'd2, 64'hFF);
    end
    for (int i = 0; i < 32; i++) begin
      rdReg(2'd1, rd); chk("R10 buffer 1 data", rd, pat(1, i));
      rdReg(2'd2, rd); chk("R4 generated parity", rd, par(pat(1, i)));
    end
    wr(2'd0, ctl(5, 0, 0, 0));
    rdReg(2'd1, rd); chk("R10 buffer 0 untouched", rd, pat(0, 5));
    rdReg(2'd2, rd); chk("R10 buffer 0 check untouched", rd, 64'(5 ^ 8'hA5));

    // Staging without commit, stepping off (R2, R5, R7)
    wr(2'd0, ctl(3, 0, 0, 0));
    wr(2'd1, 64'hDEAD_BEEF_0123_4567);
    rdReg(2'd1, rd); chk("R2 staged not stored", rd, pat(0, 3));
    rdReg(2'd1, rd); chk("R7 data read repeat", rd, pat(0, 3));
    rdReg(2'd0, rd); chk("R7 pointer after data reads", rd, ctl(3, 0, 0, 0));
    wr(2'd2, 64'h3C);
    rdReg(2'd1, rd); chk("R2 committed word", rd, 64'hDEAD_BEEF_0123_4567);
    rdReg(2'd2, rd); chk("R3 committed check", rd, 64'h3C);
    rdReg(2'd0, rd); chk("R5 hold with stepping off", rd, ctl(3, 0, 0, 0));

    // Circular read across the wrap (R6)
    wr(2'd0, ctl(30, 1, 1, 0));
    for (int k = 0; k < 4; k++) begin
      int idx;
      idx = (30 + k) % 32;
      rdReg(2'd1, rd); chk("R6 wrap read data", rd, pat(1, idx));
      rdReg(2'd2, rd); chk("R6 wrap read check", rd, par(pat(1, idx)));
    end
    rdReg(2'd0, rd); chk("R6 pointer after wrap", rd, ctl(2, 1, 1, 0));

    // Two-half line load: second half at entry 8 (R9)
    wr(2'd0, ctl(8, 0, 1, 1));
    wr(2'd1, 64'h0F0F_0F0F_0F0F_0F0F);
    wr(2'd2, 64'h0);
    rdReg(2'd0, rd); chk("R9 ctrl fields after step", rd, ctl(9, 0, 1, 1));
    wr(2'd0, ctl(8, 0, 0, 0));
    rdReg(2'd1, rd); chk("R9 reposition data", rd, 64'h0F0F_0F0F_0F0F_0F0F);
    rdReg(2'd2, rd); chk("R4 parity of half", rd, 64'h0);

    // Unused address (R11)
    wr(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    rdReg(2'd3, rd); chk("R11 unused reads zero", rd, 64'd0);
    rdReg(2'd0, rd); chk("R11 ctrl unchanged", rd, ctl(8, 0, 0, 0));
    rdReg(2'd1, rd); chk("R11 data unchanged", rd, 64'h0F0F_0F0F_0F0F_0F0F);

    // Reset again (R1)
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    rdReg(2'd0, rd); chk("R1 ctrl after reset", rd, 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule